// File: doc/BRIEF.md
# Flash Page Translation Writer

This block lets a client read and write logical pages held in a small model of a flash array. The array is built of erase blocks, and each erase block holds `PAGES` pages. Every transfer moves one whole page, which is one `DATA_W`-bit word here. A logical block number is mapped to a physical block. A page can be programmed only while it is still erased.

When a write hits a page that is already programmed, the controller relocates the whole block. It picks a spare block, erases it through a fixed busy period that stands for the slow flash erase, and writes the new page into it. It then copies every other programmed page across from the old block. Only after the copy does it switch the mapping, and the old block becomes a spare.

Each physical block keeps an erase count. The spare block chosen is the one with the lowest count, and a block whose count has reached `WEAR_LIMIT` is never chosen again. When no block qualifies, the write is refused with an error.

The controller is a six-state machine:
- `S_IDLE` accepts requests.
- `S_PICK` selects the spare block.
- `S_ERASE` runs the erase delay.
- `S_PROG` writes the new page.
- `S_COPY` walks every page index.
- `S_REMAP` commits the mapping.

Its transitions are:
- IDLE→PICK: an accepted write hits a programmed page.
- PICK→ERASE: a candidate block exists.
- PICK→IDLE: no candidate exists, so the write ends in error.
- ERASE→PROG: the erase counter expires.
- PROG→COPY: always, after one cycle.
- COPY→REMAP: after the last page index.
- REMAP→IDLE: always.

Top module: `ftl_page_writer`

## Requirements
- R1: After reset the block is idle with no response pending. Logical block i maps to physical block i, blocks from `NUM_LBLK` upward are spare, and every page reads as all ones.
- R2: An accepted read answers in the following cycle with `rsp_valid`=1 and `rsp_err`=0. It returns the page data and the physical block holding it. A page never programmed returns all ones.
- R3: A page is programmed only while erased. A write to an erased page of the mapped block is programmed in place and answered in the following cycle, with no busy period and the mapped block reported.
- R4: A write to a programmed page relocates the block. The new block is erased and receives the new data, and every other programmed page is copied to the same index. Never-programmed pages stay all ones. The response reports the new physical block.
- R5: A relocation holds `busy` for exactly `ERASE_CYC + PAGES + 3` cycles: one to pick, `ERASE_CYC` to erase, one to program, `PAGES` to copy and one to remap.
- R6: `busy` is high throughout a relocation and `rsp_valid` is never high while `busy` is high. A request presented while busy is ignored: it produces no response and changes no data.
- R7: The block chosen for relocation is a spare block whose erase count is below `WEAR_LIMIT`. It has the lowest erase count among such blocks, and on a tie the lowest index wins.
- R8: Every erase adds one to the erased block's count. A block whose count has reached `WEAR_LIMIT` is never erased again.
- R9: If no spare block qualifies, the write is answered with `rsp_err`=1 after one busy cycle and reports the current block. Data and mapping stay unchanged.
- R10: The logical-to-physical mapping changes only at the end of a relocation, after the copy. At that point the old block becomes a spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write page, 0 = read page |
| req_lblk | input | $clog2(NUM_LBLK) | Logical block number |
| req_page | input | $clog2(PAGES) | Page index within the block |
| req_wdata | input | DATA_W | Page data for a write |
| busy | output | 1 | Relocation in progress; requests are ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Write refused: no usable spare block |
| rsp_rdata | output | DATA_W | Page data for a read |
| rsp_pblk | output | $clog2(NUM_BLK) | Physical block holding the page after the operation |

## Verification
Some properties are checked on every cycle:
- No page is ever programmed while it is already programmed.
- No block at its wear limit is erased.
- Any block chosen is spare and below the limit.
- `busy` rises only after a write, and it never overlaps a response.
- An error only comes as part of a response.
- The mapping holds still outside the remap step.

Only the scenarios can show the rest: that copied pages keep their data across several relocations, the exact busy length, the lowest-count and lowest-index choice among spares, that a request during busy is dropped, and that the refusal arrives once every spare block has worn out.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PICK  = 3'd1,
        S_ERASE = 3'd2,
        S_PROG  = 3'd3,
        S_COPY  = 3'd4,
        S_REMAP = 3'd5
    } ftl_state_e;

endpackage

// File: rtl/ftl_page_store.sv
module ftl_page_store #(
    parameter int NUM_BLK = 8,
    parameter int PAGES   = 32,
    parameter int DATA_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NUM_BLK)-1:0] wr_blk,
    input  logic [$clog2(PAGES)-1:0]   wr_pg,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       erase_en,
    input  logic [$clog2(NUM_BLK)-1:0] erase_blk,
    input  logic [$clog2(NUM_BLK)-1:0] rd_blk,
    input  logic [$clog2(PAGES)-1:0]   rd_pg,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_prog
);
    localparam int BW    = $clog2(NUM_BLK);
    localparam int DEPTH = NUM_BLK * PAGES;
    localparam int AW    = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PAGES-1:0]  prog_q [NUM_BLK];
    logic [AW-1:0]     wa;
    logic [AW-1:0]     ra;

    assign wa = AW'(wr_blk) * AW'(PAGES) + AW'(wr_pg);
    assign ra = AW'(rd_blk) * AW'(PAGES) + AW'(rd_pg);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wa] <= wr_data;
        end
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prog_q[b] <= '0;
            end else if (erase_en && erase_blk == BW'(b)) begin
                prog_q[b] <= '0;
            end else if (wr_en && wr_blk == BW'(b)) begin
                prog_q[b][wr_pg] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_prog = prog_q[rd_blk][rd_pg];
        rd_data = rd_prog ? mem[ra] : '1;
    end

    AST_PROG_ONLY_ERASED: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !prog_q[wr_blk][wr_pg]); // R3
    AST_NO_WRITE_DURING_ERASE: assert property (@(posedge clk) disable iff (!rst_n) erase_en |-> !wr_en); // R4

endmodule

// File: rtl/ftl_wear_table.sv
module ftl_wear_table #(
    parameter int NUM_BLK    = 8,
    parameter int WEAR_LIMIT = 100000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              inc_en,
    input  logic [$clog2(NUM_BLK)-1:0]        inc_blk,
    output logic [$clog2(WEAR_LIMIT+1)-1:0]   cnt_o [NUM_BLK]
);
    localparam int BW = $clog2(NUM_BLK);
    localparam int CW = $clog2(WEAR_LIMIT + 1);

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_o[b] <= '0;
            end else if (inc_en && inc_blk == BW'(b)) begin
                cnt_o[b] <= cnt_o[b] + CW'(1);
            end
        end
    end

    AST_WORN_NEVER_ERASED: assert property (@(posedge clk) disable iff (!rst_n) inc_en |-> cnt_o[inc_blk] < CW'(WEAR_LIMIT)); // R8

endmodule

// File: rtl/ftl_blk_pick.sv
module ftl_blk_pick #(
    parameter int NUM_BLK    = 8,
    parameter int WEAR_LIMIT = 100000
) (
    input  logic [NUM_BLK-1:0]                spare_i,
    input  logic [$clog2(WEAR_LIMIT+1)-1:0]   cnt_i [NUM_BLK],
    output logic                              pick_ok,
    output logic [$clog2(NUM_BLK)-1:0]        pick_blk
);
    localparam int BW = $clog2(NUM_BLK);
    localparam int CW = $clog2(WEAR_LIMIT + 1);

    logic [CW-1:0] best_cnt;

    always_comb begin
        pick_ok  = 1'b0;
        pick_blk = '0;
        best_cnt = '0;
        for (int b = 0; b < NUM_BLK; b++) begin
            if (spare_i[b] && cnt_i[b] < CW'(WEAR_LIMIT)) begin
                if (!pick_ok || cnt_i[b] < best_cnt) begin
                    pick_ok  = 1'b1;
                    pick_blk = BW'(b);
                    best_cnt = cnt_i[b];
                end
            end
        end
    end

endmodule

// File: rtl/ftl_page_writer.sv
module ftl_page_writer #(
    parameter int NUM_BLK    = 8,
    parameter int NUM_LBLK   = 6,
    parameter int PAGES      = 32,
    parameter int DATA_W     = 16,
    parameter int ERASE_CYC  = 200000,
    parameter int WEAR_LIMIT = 100000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [$clog2(NUM_LBLK)-1:0] req_lblk,
    input  logic [$clog2(PAGES)-1:0]    req_page,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        busy,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic [$clog2(NUM_BLK)-1:0]  rsp_pblk
);
    import ftl_pkg::*;

    localparam int BW = $clog2(NUM_BLK);
    localparam int LW = $clog2(NUM_LBLK);
    localparam int PW = $clog2(PAGES);
    localparam int CW = $clog2(WEAR_LIMIT + 1);
    localparam int EW = $clog2(ERASE_CYC + 1);

    ftl_state_e state_q, state_d;

    logic [NUM_LBLK-1:0][BW-1:0] map_q;
    logic [NUM_BLK-1:0]          spare_q;
    logic [LW-1:0]               tgt_lblk_q;
    logic [PW-1:0]               tgt_page_q;
    logic [DATA_W-1:0]           tgt_data_q;
    logic [BW-1:0]               old_blk_q;
    logic [BW-1:0]               new_blk_q;
    logic [EW-1:0]               ecnt_q;
    logic [PW-1:0]               cidx_q;

    logic                        accept;
    logic                        erase_last;
    logic                        copy_last;

    logic                        st_wr_en;
    logic [BW-1:0]               st_wr_blk;
    logic [PW-1:0]               st_wr_pg;
    logic [DATA_W-1:0]           st_wr_data;
    logic                        st_erase_en;
    logic [BW-1:0]               st_rd_blk;
    logic [PW-1:0]               st_rd_pg;
    logic [DATA_W-1:0]           st_rd_data;
    logic                        st_rd_prog;

    logic [CW-1:0]               wear_cnt [NUM_BLK];
    logic                        pick_ok;
    logic [BW-1:0]               pick_blk;

    assign busy       = (state_q != S_IDLE);
    assign accept     = req_valid && (state_q == S_IDLE);
    assign erase_last = (ecnt_q == EW'(ERASE_CYC - 1));
    assign copy_last  = (cidx_q == PW'(PAGES - 1));

    ftl_page_store #(
        .NUM_BLK (NUM_BLK),
        .PAGES   (PAGES),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_wr_en),
        .wr_blk    (st_wr_blk),
        .wr_pg     (st_wr_pg),
        .wr_data   (st_wr_data),
        .erase_en  (st_erase_en),
        .erase_blk (new_blk_q),
        .rd_blk    (st_rd_blk),
        .rd_pg     (st_rd_pg),
        .rd_data   (st_rd_data),
        .rd_prog   (st_rd_prog)
    );

    ftl_wear_table #(
        .NUM_BLK    (NUM_BLK),
        .WEAR_LIMIT (WEAR_LIMIT)
    ) u_wear (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (st_erase_en),
        .inc_blk (new_blk_q),
        .cnt_o   (wear_cnt)
    );

    ftl_blk_pick #(
        .NUM_BLK    (NUM_BLK),
        .WEAR_LIMIT (WEAR_LIMIT)
    ) u_pick (
        .spare_i  (spare_q),
        .cnt_i    (wear_cnt),
        .pick_ok  (pick_ok),
        .pick_blk (pick_blk)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept && req_write && st_rd_prog) state_d = S_PICK;
            S_PICK:  state_d = pick_ok ? S_ERASE : S_IDLE;
            S_ERASE: if (erase_last) state_d = S_PROG;
            S_PROG:  state_d = S_COPY;
            S_COPY:  if (copy_last) state_d = S_REMAP;
            S_REMAP: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Control outputs towards page store and wear table
    always_comb begin
        st_wr_en    = 1'b0;
        st_wr_blk   = map_q[req_lblk];
        st_wr_pg    = req_page;
        st_wr_data  = req_wdata;
        st_erase_en = 1'b0;
        st_rd_blk   = map_q[req_lblk];
        st_rd_pg    = req_page;
        unique case (state_q)
            S_IDLE: begin
                if (accept && req_write && !st_rd_prog) st_wr_en = 1'b1;
            end
            S_ERASE: begin
                if (erase_last) st_erase_en = 1'b1;
            end
            S_PROG: begin
                st_wr_en   = 1'b1;
                st_wr_blk  = new_blk_q;
                st_wr_pg   = tgt_page_q;
                st_wr_data = tgt_data_q;
            end
            S_COPY: begin
                st_rd_blk  = old_blk_q;
                st_rd_pg   = cidx_q;
                st_wr_blk  = new_blk_q;
                st_wr_pg   = cidx_q;
                st_wr_data = st_rd_data;
                if (cidx_q != tgt_page_q && st_rd_prog) st_wr_en = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // Datapath and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LBLK; i++) map_q[i] <= BW'(i);
            for (int b = 0; b < NUM_BLK; b++) spare_q[b] <= (b >= NUM_LBLK);
            tgt_lblk_q <= '0;
            tgt_page_q <= '0;
            tgt_data_q <= '0;
            old_blk_q  <= '0;
            new_blk_q  <= '0;
            ecnt_q     <= '0;
            cidx_q     <= '0;
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_rdata  <= '0;
            rsp_pblk   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        tgt_lblk_q <= req_lblk;
                        tgt_page_q <= req_page;
                        tgt_data_q <= req_wdata;
                        old_blk_q  <= map_q[req_lblk];
                        if (!req_write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= st_rd_data;
                            rsp_pblk  <= map_q[req_lblk];
                        end else if (!st_rd_prog) begin
                            rsp_valid <= 1'b1;
                            rsp_pblk  <= map_q[req_lblk];
                        end
                    end
                end
                S_PICK: begin
                    if (pick_ok) begin
                        new_blk_q <= pick_blk;
                        ecnt_q    <= '0;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_pblk  <= old_blk_q;
                    end
                end
                S_ERASE: begin
                    ecnt_q <= ecnt_q + EW'(1);
                end
                S_PROG: begin
                    cidx_q <= '0;
                end
                S_COPY: begin
                    cidx_q <= cidx_q + PW'(1);
                end
                S_REMAP: begin
                    map_q[tgt_lblk_q]  <= new_blk_q;
                    spare_q[old_blk_q] <= 1'b1;
                    spare_q[new_blk_q] <= 1'b0;
                    rsp_valid          <= 1'b1;
                    rsp_pblk           <= new_blk_q;
                end
                default: begin
                end
            endcase
        end
    end

    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_PICK && pick_ok) |-> (spare_q[pick_blk] && wear_cnt[pick_blk] < CW'(WEAR_LIMIT))); // R7
    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req_valid && req_write)); // R6
    AST_RSP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !busy); // R6
    AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> rsp_valid); // R9
    AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (state_q != S_REMAP) |=> $stable(map_q)); // R10

endmodule

// File: tb/sim_ftl_page_writer.sv
`timescale 1ns/1ps
module sim_ftl_page_writer;

    localparam int NB  = 4;
    localparam int NL  = 2;
    localparam int PG  = 32;
    localparam int DW  = 8;
    localparam int EC  = 12;
    localparam int WL  = 2;
    localparam int RELOC = EC + PG + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [0:0]    req_lblk = '0;
    logic [4:0]    req_page = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy;
    logic          rsp_valid;
    logic          rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [1:0]    rsp_pblk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        bit          rd;
        bit          err;
        logic [7:0]  data;
        logic [1:0]  pblk;
        string       req;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    ftl_page_writer #(
        .NUM_BLK    (NB),
        .NUM_LBLK   (NL),
        .PAGES      (PG),
        .DATA_W     (DW),
        .ERASE_CYC  (EC),
        .WEAR_LIMIT (WL)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_lblk  (req_lblk),
        .req_page  (req_page),
        .req_wdata (req_wdata),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .rsp_pblk  (rsp_pblk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected responses and compares
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R6 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(rsp_err == e.err, {e.req, " err"}, rsp_err, e.err);
                    check(rsp_pblk == e.pblk, {e.req, " pblk"}, rsp_pblk, e.pblk);
                    if (e.rd) check(rsp_rdata == e.data, {e.req, " data"}, rsp_rdata, e.data);
                end
            end
        end
    end

    // Driver: issue one request, push expectation, measure busy length
    task automatic op(input bit wr, input int lb, input int pg, input logic [7:0] d,
                      input bit eerr, input logic [7:0] ed, input int epb,
                      input string req, input int ebusy, input bit poke);
        int n;
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_lblk  = 1'(lb);
        req_page  = 5'(pg);
        req_wdata = d;
        e.rd = !wr; e.err = eerr; e.data = ed; e.pblk = 2'(epb); e.req = req;
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (busy) begin
            if (poke && n == 2) begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_lblk  = 1'b1;
                req_page  = 5'd0;
                req_wdata = 8'h55;
            end else begin
                req_valid = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(n == ebusy, {req, " busy cycles"}, n, ebusy);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(rsp_valid == 1'b0, "R1 rsp in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && rsp_valid == 1'b0, "R1 idle after reset", {busy, rsp_valid}, 0);

        // R1/R2: fresh pages read as all ones, identity mapping
        op(0, 0, 3, 8'h00, 0, 8'hFF, 0, "R1 R2 read erased lb0", 0, 0);
        op(0, 1, 9, 8'h00, 0, 8'hFF, 1, "R1 R2 read erased lb1", 0, 0);
        // R3: direct programming of erased pages
        op(1, 0, 3, 8'hA1, 0, 8'h00, 0, "R3 direct write p3", 0, 0);
        op(1, 0, 5, 8'hB2, 0, 8'h00, 0, "R3 direct write p5", 0, 0);
        op(0, 0, 3, 8'h00, 0, 8'hA1, 0, "R2 read back p3", 0, 0);
        // R4/R5/R6/R7: relocation to block 2 (tie, lowest index), poke ignored
        op(1, 0, 3, 8'hC3, 0, 8'h00, 2, "R4 R5 R7 relocate to pb2", RELOC, 1);
        op(0, 0, 3, 8'h00, 0, 8'hC3, 2, "R4 new data", 0, 0);
        op(0, 0, 5, 8'h00, 0, 8'hB2, 2, "R4 copied page", 0, 0);
        op(0, 0, 7, 8'h00, 0, 8'hFF, 2, "R4 unwritten stays erased", 0, 0);
        op(0, 1, 0, 8'h00, 0, 8'hFF, 1, "R6 busy request ignored", 0, 0);
        // R10: old block 0 now spare; R7 tie picks pb0
        op(1, 0, 5, 8'hD4, 0, 8'h00, 0, "R10 R7 reuse freed pb0", RELOC, 0);
        op(1, 1, 0, 8'h11, 0, 8'h00, 1, "R3 direct write lb1", 0, 0);
        // R7/R8: pb2 count 1, pb3 count 0 -> pb3
        op(1, 1, 0, 8'h22, 0, 8'h00, 3, "R7 R8 lowest count pb3", RELOC, 0);
        op(1, 0, 5, 8'hE5, 0, 8'h00, 1, "R7 lowest count pb1", RELOC, 0);
        op(1, 0, 5, 8'hF6, 0, 8'h00, 0, "R7 tie picks pb0", RELOC, 0);
        op(1, 0, 5, 8'h07, 0, 8'h00, 1, "R8 pb1 second erase", RELOC, 0);
        op(1, 0, 5, 8'h18, 0, 8'h00, 2, "R8 worn pb0 skipped", RELOC, 0);
        // R9: all spares worn
        op(1, 0, 5, 8'h29, 1, 8'h00, 2, "R9 no spare error", 1, 0);
        op(0, 0, 5, 8'h00, 0, 8'h18, 2, "R9 data unchanged", 0, 0);
        op(0, 0, 3, 8'h00, 0, 8'hC3, 2, "R4 page survives relocations", 0, 0);
        op(0, 1, 0, 8'h00, 0, 8'h22, 3, "R10 lb1 mapping", 0, 0);

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R6 responses outstanding", sbq.size(), 0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule